// File: doc/BRIEF.md
# Pointer Register File with Post-Modify Address Generation

This block holds the integer registers used to form memory addresses. It has 22 general 32-bit registers at indices 1 to 22 and a constant-zero register at index 0. In each cycle it produces up to three memory operand addresses, one per operand field (X, Y, Z). After an address is used, the block can advance the pointer that produced it. The step is either a fixed amount set by the access size or the value of a stride register. Only a fixed band of registers may act as pointers, and only another fixed band may act as strides.

The block also has two combinational read ports and one write port for integer instructions. A dedicated write path captures the faulting program counter into index 20 when an error exception is taken. Indices 21 (stack pointer) and 22 (exception-table base) are driven out continuously. If any operand field is out of range, the block raises an illegal-operand flag for that cycle and no register changes.

Top module: `addr_regfile`

## Requirements
- R1: Index 0 reads as zero on every read path, and writes to it are dropped. Indices 23 to 31 also read as zero and have no storage.
- R2: The integer write port updates the selected register at the clock edge. Both read ports return the current contents combinationally.
- R3: Each enabled operand field outputs its pointer's value from before the edge. Field X is bits [31:0] of the address bus, Y is [63:32] and Z is [95:64]. The selector of field f is bits [5f+4:5f].
- R4: A fixed-step update (mode bit 0) adds the access size to the pointer. The size codes are 0 for byte (+1), 1 for half-word (+2) and 2 for word (+4).
- R5: A stride update (mode bit 1) adds the value of the named stride register as it stood before the edge, modulo 2^32.
- R6: A pointer selector outside 1 to 14 on an enabled field raises illegal_o in that cycle. That cycle then changes no register, and this includes the integer write and the exception capture.
- R7: illegal_o is also raised, with the same freeze, by either of two cases on an updating field. One is a stride selector outside 15 to 19 in stride mode. The other is size code 3 in fixed-step mode.
- R8: When several fields name the same pointer, every field outputs the old value. If more than one of them updates it, Z has priority over Y, and Y has priority over X.
- R9: A pointer update has priority over an integer write to the same register in the same cycle.
- R10: exc_i writes exc_pc_i into index 20, and this has priority over an integer write to index 20.
- R11: sp_o always shows index 21 and evtp_o always shows index 22.
- R12: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_en_i | input | 3 | Operand field enables, bit f for field f (X=0, Y=1, Z=2) |
| ptr_upd_i | input | 3 | Post-modify request per field |
| ptr_mode_i | input | 3 | Per field: 0 for fixed step, 1 for stride register |
| ptr_sel_i | input | 15 | Pointer selectors, 5 bits per field |
| ptr_inc_sel_i | input | 15 | Stride register selectors, 5 bits per field |
| ptr_size_i | input | 6 | Access size codes, 2 bits per field |
| ptr_addr_o | output | 96 | Operand addresses, 32 bits per field |
| rd_a_sel_i | input | 5 | Read port A selector |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_sel_i | input | 5 | Read port B selector |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Integer write enable |
| wr_sel_i | input | 5 | Integer write selector |
| wr_data_i | input | 32 | Integer write data |
| exc_i | input | 1 | Error exception taken |
| exc_pc_i | input | 32 | Program counter to save |
| sp_o | output | 32 | Stack pointer (index 21) |
| evtp_o | output | 32 | Exception-table base (index 22) |
| illegal_o | output | 1 | Illegal operand in this cycle |

## Verification
The bench targets collisions on a single register: two fields naming the same pointer, an integer write landing on a pointer being advanced, and an exception capture racing an integer write to index 20. A design with the wrong priority would leave the losing value in the register, and one that read the new value would show an address advanced early. It drives out-of-range pointer and stride selectors and the reserved size code together with writes. A design that only blocked the pointer update would still let the integer write or the exception capture through. It also checks that a negative stride wraps correctly, that writes to index 0 are dropped, and that selectors above 22 read as zero.

// File: rtl/addr_rf_pkg.sv
package addr_rf_pkg;
  localparam int NPTR     = 3;
  localparam int NREG     = 22;
  localparam int IW       = 5;
  localparam int PTR_LO   = 1;
  localparam int PTR_HI   = 14;
  localparam int INC_LO   = 15;
  localparam int INC_HI   = 19;
  localparam int EPC_IDX  = 20;
  localparam int SP_IDX   = 21;
  localparam int EVTP_IDX = 22;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/addr_rf_store.sv
module addr_rf_store #(
  parameter int DW   = 32,
  parameter int NREG = 22,
  parameter int IW   = 5,
  parameter int NWP  = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NWP-1:0]         we_i,
  input  logic [NWP*IW-1:0]      widx_i,
  input  logic [NWP*DW-1:0]      wdat_i,
  output logic [(NREG+1)*DW-1:0] rf_o
);
  assign rf_o[DW-1:0] = '0;

  // later write port wins
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q, d;
    always_comb begin
      d = q;
      for (int p = 0; p < NWP; p++)
        if (we_i[p] && widx_i[p*IW +: IW] == IW'(g + 1)) d = wdat_i[p*DW +: DW];
    end
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q <= '0;
      else         q <= d;
    assign rf_o[(g+1)*DW +: DW] = q;
  end
endmodule

// File: rtl/addr_rf_agu.sv
module addr_rf_agu
  import addr_rf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] ptr_val_i,
  input  logic [DW-1:0] inc_val_i,
  input  logic          inc_mode_i,
  input  acc_size_e     size_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] next_o
);
  logic [DW-1:0] step;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: step = DW'(1);
      SZ_HALF: step = DW'(2);
      SZ_WORD: step = DW'(4);
      default: step = '0;
    endcase
  end

  assign addr_o = ptr_val_i;
  assign next_o = ptr_val_i + (inc_mode_i ? inc_val_i : step);
endmodule

// File: rtl/addr_rf_legal.sv
module addr_rf_legal
  import addr_rf_pkg::*;
#(
  parameter int NP = 3
) (
  input  logic [NP-1:0]    en_i,
  input  logic [NP-1:0]    upd_i,
  input  logic [NP-1:0]    mode_i,
  input  logic [NP*IW-1:0] sel_i,
  input  logic [NP*IW-1:0] inc_sel_i,
  input  logic [NP*2-1:0]  size_i,
  output logic             illegal_o
);
  logic [NP-1:0] bad;

  for (genvar f = 0; f < NP; f++) begin : g_fld
    logic [IW-1:0] s, i;
    logic bad_ptr, bad_inc, bad_sz;
    assign s       = sel_i[f*IW +: IW];
    assign i       = inc_sel_i[f*IW +: IW];
    assign bad_ptr = en_i[f] && (s < IW'(PTR_LO) || s > IW'(PTR_HI));
    assign bad_inc = en_i[f] && upd_i[f] && mode_i[f] && (i < IW'(INC_LO) || i > IW'(INC_HI));
    assign bad_sz  = en_i[f] && upd_i[f] && !mode_i[f] && (size_i[f*2 +: 2] == SZ_RSVD);
    assign bad[f]  = bad_ptr | bad_inc | bad_sz;
  end

  assign illegal_o = |bad;
endmodule

// File: rtl/addr_regfile.sv
module addr_regfile
  import addr_rf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPTR-1:0]    ptr_en_i,
  input  logic [NPTR-1:0]    ptr_upd_i,
  input  logic [NPTR-1:0]    ptr_mode_i,
  input  logic [NPTR*IW-1:0] ptr_sel_i,
  input  logic [NPTR*IW-1:0] ptr_inc_sel_i,
  input  logic [NPTR*2-1:0]  ptr_size_i,
  output logic [NPTR*DW-1:0] ptr_addr_o,
  input  logic [IW-1:0]    rd_a_sel_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [IW-1:0]    rd_b_sel_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             exc_i,
  input  logic [DW-1:0]    exc_pc_i,
  output logic [DW-1:0]    sp_o,
  output logic [DW-1:0]    evtp_o,
  output logic             illegal_o
);
  localparam int NWP = NPTR + 2;
  localparam int EXC_P = NPTR + 1;

  logic [(NREG+1)*DW-1:0] rf_q;
  logic [NWP-1:0]         we;
  logic [NWP*IW-1:0]      widx;
  logic [NWP*DW-1:0]      wdat;

  function automatic logic [DW-1:0] rd_reg(input logic [IW-1:0] idx);
    if (int'(idx) > NREG) return '0;
    return rf_q[idx*DW +: DW];
  endfunction

  addr_rf_legal #(.NP(NPTR)) u_legal (
    .en_i      (ptr_en_i),
    .upd_i     (ptr_upd_i),
    .mode_i    (ptr_mode_i),
    .sel_i     (ptr_sel_i),
    .inc_sel_i (ptr_inc_sel_i),
    .size_i    (ptr_size_i),
    .illegal_o (illegal_o)
  );

  // port 0: integer write (lowest priority)
  assign we[0]           = wr_en_i & ~illegal_o;
  assign widx[0 +: IW]   = wr_sel_i;
  assign wdat[0 +: DW]   = wr_data_i;

  // ports 1..NPTR: X, Y, Z in rising priority
  for (genvar f = 0; f < NPTR; f++) begin : g_ptr
    logic [DW-1:0] nxt;
    addr_rf_agu #(.DW(DW)) u_agu (
      .ptr_val_i  (rd_reg(ptr_sel_i[f*IW +: IW])),
      .inc_val_i  (rd_reg(ptr_inc_sel_i[f*IW +: IW])),
      .inc_mode_i (ptr_mode_i[f]),
      .size_i     (acc_size_e'(ptr_size_i[f*2 +: 2])),
      .addr_o     (ptr_addr_o[f*DW +: DW]),
      .next_o     (nxt)
    );
    assign we[f+1]              = ptr_en_i[f] & ptr_upd_i[f] & ~illegal_o;
    assign widx[(f+1)*IW +: IW] = ptr_sel_i[f*IW +: IW];
    assign wdat[(f+1)*DW +: DW] = nxt;
  end

  // last port: exception PC capture (highest priority)
  assign we[EXC_P]              = exc_i & ~illegal_o;
  assign widx[EXC_P*IW +: IW]   = IW'(EPC_IDX);
  assign wdat[EXC_P*DW +: DW]   = exc_pc_i;

  addr_rf_store #(.DW(DW), .NREG(NREG), .IW(IW), .NWP(NWP)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (widx),
    .wdat_i (wdat),
    .rf_o   (rf_q)
  );

  assign rd_a_data_o = rd_reg(rd_a_sel_i);
  assign rd_b_data_o = rd_reg(rd_b_sel_i);
  assign sp_o        = rf_q[SP_IDX*DW +: DW];
  assign evtp_o      = rf_q[EVTP_IDX*DW +: DW];
endmodule

// File: rtl/addr_rf_sva.sv
module addr_rf_sva
  import addr_rf_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [IW-1:0]          rd_a_sel_i,
  input logic [DW-1:0]          rd_a_data_o,
  input logic                   illegal_o,
  input logic                   exc_i,
  input logic [DW-1:0]          exc_pc_i,
  input logic                   z_en,
  input logic                   z_upd,
  input logic                   z_mode,
  input logic [IW-1:0]          z_sel,
  input logic [1:0]             z_size,
  input logic [DW-1:0]          z_addr,
  input logic [(NREG+1)*DW-1:0] rf_q
);
  logic          z_chk_q;
  logic [IW-1:0] z_idx_q;
  logic [DW-1:0] z_exp_q;
  logic [DW-1:0] z_step;

  assign z_step = (z_size == 2'd0) ? DW'(1) : (z_size == 2'd1) ? DW'(2) : DW'(4);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      z_chk_q <= 1'b0;
      z_idx_q <= '0;
      z_exp_q <= '0;
    end else begin
      z_chk_q <= z_en && z_upd && !z_mode && !illegal_o;
      z_idx_q <= z_sel;
      z_exp_q <= z_addr + z_step;
    end

  p_zero_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_sel_i == '0 |-> rd_a_data_o == '0);

  p_illegal_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(rf_q));

  p_exc_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !illegal_o |=> rf_q[EPC_IDX*DW +: DW] == $past(exc_pc_i));

  // Z has top priority among pointer writes (R8, R4)
  p_z_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_chk_q |-> rf_q[z_idx_q*DW +: DW] == z_exp_q);
endmodule

bind addr_regfile addr_rf_sva #(.DW(DW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_sel_i  (rd_a_sel_i),
  .rd_a_data_o (rd_a_data_o),
  .illegal_o   (illegal_o),
  .exc_i       (exc_i),
  .exc_pc_i    (exc_pc_i),
  .z_en        (ptr_en_i[2]),
  .z_upd       (ptr_upd_i[2]),
  .z_mode      (ptr_mode_i[2]),
  .z_sel       (ptr_sel_i[14:10]),
  .z_size      (ptr_size_i[5:4]),
  .z_addr      (ptr_addr_o[95:64]),
  .rf_q        (rf_q)
);

// File: tb/addr_regfile_test.sv
module addr_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ptr_en_i, ptr_upd_i, ptr_mode_i;
  logic [14:0] ptr_sel_i, ptr_inc_sel_i;
  logic [5:0]  ptr_size_i;
  logic [95:0] ptr_addr_o;
  logic [4:0]  rd_a_sel_i, rd_b_sel_i, wr_sel_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i, exc_pc_i, sp_o, evtp_o;
  logic        wr_en_i, exc_i, illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m [0:22];

  always #5 clk_i = ~clk_i;

  addr_regfile uut (.*);

  function automatic logic [31:0] mrd(input logic [4:0] i);
    return (i == 0 || i > 22) ? 32'h0 : m[i];
  endfunction

  function automatic logic m_illegal();
    logic bad = 1'b0;
    for (int f = 0; f < 3; f++) begin
      logic [4:0] s = ptr_sel_i[f*5 +: 5];
      logic [4:0] c = ptr_inc_sel_i[f*5 +: 5];
      if (ptr_en_i[f]) begin
        if (s < 1 || s > 14) bad = 1'b1;
        if (ptr_upd_i[f] && ptr_mode_i[f] && (c < 15 || c > 19)) bad = 1'b1;
        if (ptr_upd_i[f] && !ptr_mode_i[f] && ptr_size_i[f*2 +: 2] == 2'd3) bad = 1'b1;
      end
    end
    return bad;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ptr_en_i = '0; ptr_upd_i = '0; ptr_mode_i = '0;
    ptr_sel_i = '0; ptr_inc_sel_i = '0; ptr_size_i = '0;
    rd_a_sel_i = '0; rd_b_sel_i = '0;
    wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    exc_i = 1'b0; exc_pc_i = '0;
  endtask

  task automatic set_f(input int f, input logic upd, input logic mode, input logic [4:0] sel,
                       input logic [4:0] inc, input logic [1:0] sz);
    ptr_en_i[f] = 1'b1; ptr_upd_i[f] = upd; ptr_mode_i[f] = mode;
    ptr_sel_i[f*5 +: 5] = sel; ptr_inc_sel_i[f*5 +: 5] = inc; ptr_size_i[f*2 +: 2] = sz;
  endtask

  // compare everything, then advance one clock and the model
  task automatic cyc(input string tag);
    logic [31:0] old [0:22];
    logic ill;
    #1;
    ill = m_illegal();
    chk({tag, " illegal R6"}, {31'b0, illegal_o}, {31'b0, ill});
    chk({tag, " rdA R2"}, rd_a_data_o, mrd(rd_a_sel_i));
    chk({tag, " rdB R2"}, rd_b_data_o, mrd(rd_b_sel_i));
    chk({tag, " sp R11"}, sp_o, m[21]);
    chk({tag, " evtp R11"}, evtp_o, m[22]);
    for (int f = 0; f < 3; f++)
      if (ptr_en_i[f] && !ill) chk({tag, " addr R3"}, ptr_addr_o[f*32 +: 32], mrd(ptr_sel_i[f*5 +: 5]));
    @(posedge clk_i);
    old = m;
    if (!ill) begin
      if (wr_en_i && wr_sel_i != 0 && wr_sel_i <= 22) m[wr_sel_i] = wr_data_i;
      for (int f = 0; f < 3; f++)
        if (ptr_en_i[f] && ptr_upd_i[f]) begin
          logic [4:0] s = ptr_sel_i[f*5 +: 5];
          logic [31:0] st;
          case (ptr_size_i[f*2 +: 2])
            2'd0: st = 1;
            2'd1: st = 2;
            default: st = 4;
          endcase
          m[s] = old[s] + (ptr_mode_i[f] ? old[ptr_inc_sel_i[f*5 +: 5]] : st);
        end
      if (exc_i) m[20] = exc_pc_i;
    end
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    cyc("R2 write");
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [4:0] b);
    rd_a_sel_i = a; rd_b_sel_i = b;
    cyc(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 23; i++) m[i] = '0;
    idle();
    #22 rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 23; i += 2) rd("R12 reset", 5'(i), 5'(i + 1));

    wr(5'd21, 32'h0000_8000);
    wr(5'd22, 32'h0000_0400);
    wr(5'd0, 32'hDEAD_BEEF);
    rd("R1 zero", 5'd0, 5'd25);
    rd("R11 sp", 5'd21, 5'd22);

    wr(5'd3, 32'h0000_0100);
    wr(5'd4, 32'h0000_0200);
    wr(5'd5, 32'h0000_0300);
    set_f(0, 1, 0, 5'd3, 5'd0, 2'd0);
    set_f(1, 1, 0, 5'd4, 5'd0, 2'd1);
    set_f(2, 1, 0, 5'd5, 5'd0, 2'd2);
    cyc("R4 steps");
    rd("R4 readback", 5'd3, 5'd4);
    rd("R4 readback", 5'd5, 5'd0);

    wr(5'd15, 32'hFFFF_FFF8);
    wr(5'd6, 32'h0000_0004);
    set_f(0, 1, 1, 5'd6, 5'd15, 2'd0);
    cyc("R5 stride");
    set_f(0, 1, 1, 5'd6, 5'd15, 2'd0);
    cyc("R5 wrap");
    rd("R5 readback", 5'd6, 5'd15);

    set_f(0, 1, 0, 5'd0, 5'd0, 2'd0);
    wr_en_i = 1'b1; wr_sel_i = 5'd7; wr_data_i = 32'h1234_5678;
    exc_i = 1'b1; exc_pc_i = 32'hAAAA_0000;
    cyc("R6 ptr r0");
    set_f(1, 0, 0, 5'd15, 5'd0, 2'd0);
    wr_en_i = 1'b1; wr_sel_i = 5'd21; wr_data_i = 32'h5555_5555;
    cyc("R6 ptr r15");
    rd("R6 readback", 5'd7, 5'd20);

    set_f(0, 1, 1, 5'd3, 5'd14, 2'd0);
    cyc("R7 bad stride");
    set_f(2, 1, 0, 5'd3, 5'd0, 2'd3);
    wr_en_i = 1'b1; wr_sel_i = 5'd8; wr_data_i = 32'h0000_0077;
    cyc("R7 rsvd size");
    rd("R7 readback", 5'd3, 5'd8);

    set_f(0, 1, 0, 5'd3, 5'd0, 2'd0);
    set_f(1, 0, 0, 5'd3, 5'd0, 2'd0);
    set_f(2, 1, 0, 5'd3, 5'd0, 2'd2);
    cyc("R8 same ptr");
    set_f(0, 1, 0, 5'd4, 5'd0, 2'd2);
    set_f(1, 1, 0, 5'd4, 5'd0, 2'd0);
    cyc("R8 Y over X");
    rd("R8 readback", 5'd3, 5'd4);

    set_f(0, 1, 0, 5'd5, 5'd0, 2'd1);
    wr_en_i = 1'b1; wr_sel_i = 5'd5; wr_data_i = 32'hFFFF_0000;
    cyc("R9 ptr vs wr");
    rd("R9 readback", 5'd5, 5'd0);

    wr_en_i = 1'b1; wr_sel_i = 5'd20; wr_data_i = 32'h1111_1111;
    exc_i = 1'b1; exc_pc_i = 32'h0000_ABCD;
    cyc("R10 exc vs wr");
    rd("R10 readback", 5'd20, 5'd21);

    for (int k = 0; k < 400; k++) begin
      for (int f = 0; f < 3; f++)
        if ($urandom_range(0, 1) == 1)
          set_f(f, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                5'($urandom_range(0, 15)), 5'($urandom_range(14, 20)), 2'($urandom_range(0, 3)));
      wr_en_i = 1'($urandom_range(0, 1));
      wr_sel_i = 5'($urandom_range(0, 23));
      wr_data_i = $urandom;
      exc_i = ($urandom_range(0, 7) == 0);
      exc_pc_i = $urandom;
      rd_a_sel_i = 5'($urandom_range(0, 31));
      rd_b_sel_i = 5'($urandom_range(0, 22));
      cyc("R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule